// File: doc/BRIEF.md
# Vector Unit Access Trap Checker

The block decides whether a vector-extension instruction may execute at the current privilege level. It looks at the enable and trap controls owned by three privilege tiers: the kernel tier (levels 0 and 1), the hypervisor tier (level 2) and the monitor tier (level 3). When execution is refused, it reports whether the trap is a vector trap or a scalar FP/SIMD trap, and which privilege level takes the trap.

A caller presents a snapshot of the current level and all control fields, together with a one-cycle request strobe. The verdict appears on registered outputs one clock later, marked by a matching response pulse. The tiers are checked in a fixed order, and the first failing check decides the outcome. Within each tier the vector control is checked before the FP control. A vector trap that would go to level 1 is sent to level 2 instead when the hypervisor is enabled and its trap-general control is set.

Top module: `vec_trap_chk`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_valid` is 0.
- R2: A `req_valid` pulse produces a `rsp_valid` pulse exactly one clock later. The outputs reflect the inputs sampled with the request. `rsp_valid` is 0 in a cycle that follows no request.
- R3: At levels 0 and 1, each 2-bit kernel enable field is decoded as follows. Bit 0 clear refuses at both levels. Value 2'b01 refuses at level 0 only. Value 2'b11 permits. A refusal targets level 1 (`target_lvl` = 1).
- R4: At levels 0 and 1, the kernel vector field is checked first. When both kernel fields refuse, the result is a vector trap (`trap_fp` = 0), not an FP trap (`trap_fp` = 1).
- R5: At levels 0 to 2, when the hypervisor is enabled and `host_mode` = 1, the 2-bit hypervisor enable fields apply. Bit 0 clear traps to level 2, vector field first. The single trap bits are then ignored.
- R6: At levels 0 to 2, when the hypervisor is enabled and `host_mode` = 0, the hypervisor trap bits apply. A value of 1 traps to level 2, vector bit first. The 2-bit fields are then ignored.
- R7: When the monitor is present, `mon_vec_on` = 0 gives a vector trap to level 3, and `mon_fp_trap` = 1 gives an FP trap to level 3, at any current level. When the monitor is absent, both are ignored.
- R8: Kernel checks take priority over hypervisor checks, and hypervisor checks take priority over monitor checks. The first failing check decides the result.
- R9: A vector trap that would target level 1 targets level 2 when `hyp_present` = 1 and `trap_gen` = 1. An FP trap that targets level 1 is not redirected.
- R10: When no check fails, `allowed` = 1, `trap_fp` = 0 and `target_lvl` = 0. When a check fails, `allowed` = 0.
- R11: Kernel fields have no effect at levels 2 and 3. Hypervisor controls have no effect at level 3 or when `hyp_present` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; inputs sampled on this cycle |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| hyp_present | input | 1 | Hypervisor level enabled |
| mon_present | input | 1 | Monitor level implemented |
| host_mode | input | 1 | Hypervisor uses 2-bit enable fields |
| trap_gen | input | 1 | Redirect level-1 vector traps to level 2 |
| low_vec_en | input | 2 | Kernel vector enable field |
| low_fp_en | input | 2 | Kernel FP/SIMD enable field |
| hyp_vec_en | input | 2 | Hypervisor vector enable field (host mode) |
| hyp_fp_en | input | 2 | Hypervisor FP enable field (host mode) |
| hyp_vec_trap | input | 1 | Hypervisor vector trap bit (non-host mode) |
| hyp_fp_trap | input | 1 | Hypervisor FP trap bit (non-host mode) |
| mon_vec_on | input | 1 | Monitor vector enable, 0 traps |
| mon_fp_trap | input | 1 | Monitor FP trap bit, 1 traps |
| rsp_valid | output | 1 | Verdict valid pulse |
| allowed | output | 1 | Instruction may execute |
| trap_fp | output | 1 | Trap kind: 0 vector, 1 FP/SIMD |
| target_lvl | output | 2 | Level that takes the trap |

## Verification
The bench targets the enable value 2'b01, which must refuse at level 0 but permit at level 1. A decoder that confuses the two bits either traps kernel code or lets user code run. It sets several failing controls at once in different tiers to expose a wrong priority order, which would report a monitor or FP trap where a kernel vector trap is expected. It also checks that redirection applies only to vector traps aimed at level 1 while trap-general is set. Finally, it checks that the controls of a tier out of scope leave the verdict unchanged; a design that ignores the level or presence gating would trap where it should allow.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  parameter int LVL_W = 2;
  parameter int EN_W  = 2;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [EN_W-1:0]  en_t;

  localparam lvl_t LVL_USER  = lvl_t'(0);
  localparam lvl_t LVL_KERN  = lvl_t'(1);
  localparam lvl_t LVL_HYP   = lvl_t'(2);
  localparam lvl_t LVL_MON   = lvl_t'(3);

  typedef struct packed {
    logic fail;
    logic is_fp;
    lvl_t target;
  } verdict_t;

  localparam verdict_t VERDICT_PASS = '{fail: 1'b0, is_fp: 1'b0, target: LVL_USER};

  // Kernel-style 2-bit field: low bit clear refuses, 01 refuses only at the lowest level
  function automatic logic kern_field_refuses(input en_t f, input logic at_user);
    logic r;
    if (!f[0])       r = 1'b1;
    else if (!f[1])  r = at_user;
    else             r = 1'b0;
    return r;
  endfunction

  // Hypervisor host-mode field: only the low bit matters
  function automatic logic host_field_refuses(input en_t f);
    return !f[0];
  endfunction

  // Vector check wins over FP check inside one tier
  function automatic verdict_t tier_verdict(input logic vec_bad, input logic fp_bad,
                                            input lvl_t tgt);
    verdict_t v;
    v = VERDICT_PASS;
    if (vec_bad) begin
      v.fail = 1'b1; v.is_fp = 1'b0; v.target = tgt;
    end else if (fp_bad) begin
      v.fail = 1'b1; v.is_fp = 1'b1; v.target = tgt;
    end
    return v;
  endfunction

  // First failing tier decides
  function automatic verdict_t first_fail(input verdict_t hi, input verdict_t lo);
    return hi.fail ? hi : lo;
  endfunction
endpackage

// File: rtl/vtc_kern_gate.sv
module vtc_kern_gate
  import vtc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lvl_t     cur_lvl,
  input  en_t      vec_en,
  input  en_t      fp_en,
  output logic     vec_refuse,
  output logic     fp_refuse,
  output verdict_t verdict
);
  logic in_scope;
  logic at_user;

  assign in_scope   = (cur_lvl == LVL_USER) || (cur_lvl == LVL_KERN);
  assign at_user    = (cur_lvl == LVL_USER);
  assign vec_refuse = in_scope && kern_field_refuses(vec_en, at_user);
  assign fp_refuse  = in_scope && kern_field_refuses(fp_en, at_user);
  assign verdict    = tier_verdict(vec_refuse, fp_refuse, LVL_KERN);

  // R11: kernel fields are out of scope above level 1
  a_r11_kern_quiet_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == LVL_HYP || cur_lvl == LVL_MON) |-> !verdict.fail);
  // R3: fully enabled fields never refuse
  a_r3_full_enable_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_en == 2'b11 && fp_en == 2'b11) |-> !verdict.fail);
  // R3: user-only refusal value permits at level 1
  a_r3_user_only_value: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == LVL_KERN && vec_en[0] && fp_en[0]) |-> !verdict.fail);
  // R4: vector refusal is reported as a vector trap
  a_r4_vec_first: assert property (@(posedge clk) disable iff (!rst_n)
    vec_refuse |-> (verdict.fail && !verdict.is_fp));
endmodule

// File: rtl/vtc_hyp_gate.sv
module vtc_hyp_gate
  import vtc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lvl_t     cur_lvl,
  input  logic     hyp_present,
  input  logic     host_mode,
  input  en_t      vec_en,
  input  en_t      fp_en,
  input  logic     vec_trap,
  input  logic     fp_trap,
  output logic     vec_refuse,
  output logic     fp_refuse,
  output verdict_t verdict
);
  logic in_scope;

  assign in_scope   = hyp_present && (cur_lvl != LVL_MON);
  assign vec_refuse = in_scope && (host_mode ? host_field_refuses(vec_en) : vec_trap);
  assign fp_refuse  = in_scope && (host_mode ? host_field_refuses(fp_en)  : fp_trap);
  assign verdict    = tier_verdict(vec_refuse, fp_refuse, LVL_HYP);

  // R11: hypervisor controls inert when absent or at level 3
  a_r11_hyp_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (!hyp_present || cur_lvl == LVL_MON) |-> !verdict.fail);
  // R5: in host mode the trap bits do not matter
  a_r5_host_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && vec_en[0] && fp_en[0]) |-> !verdict.fail);
  // R6: outside host mode the 2-bit fields do not matter
  a_r6_plain_fields_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_mode && !vec_trap && !fp_trap) |-> !verdict.fail);
endmodule

// File: rtl/vtc_mon_gate.sv
module vtc_mon_gate
  import vtc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mon_present,
  input  logic     vec_on,
  input  logic     fp_trap,
  output logic     vec_refuse,
  output logic     fp_refuse,
  output verdict_t verdict
);
  assign vec_refuse = mon_present && !vec_on;
  assign fp_refuse  = mon_present && fp_trap;
  assign verdict    = tier_verdict(vec_refuse, fp_refuse, LVL_MON);

  // R7: absent monitor never refuses
  a_r7_mon_absent: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_present |-> !verdict.fail);
  // R7: monitor refusals always target level 3
  a_r7_mon_target: assert property (@(posedge clk) disable iff (!rst_n)
    verdict.fail |-> (verdict.target == LVL_MON));
endmodule

// File: rtl/vec_trap_chk.sv
module vec_trap_chk
  import vtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] cur_lvl,
  input  logic       hyp_present,
  input  logic       mon_present,
  input  logic       host_mode,
  input  logic       trap_gen,
  input  logic [1:0] low_vec_en,
  input  logic [1:0] low_fp_en,
  input  logic [1:0] hyp_vec_en,
  input  logic [1:0] hyp_fp_en,
  input  logic       hyp_vec_trap,
  input  logic       hyp_fp_trap,
  input  logic       mon_vec_on,
  input  logic       mon_fp_trap,
  output logic       rsp_valid,
  output logic       allowed,
  output logic       trap_fp,
  output logic [1:0] target_lvl
);
  verdict_t kern_v, hyp_v, mon_v;
  verdict_t chosen_v, routed_v;
  logic     kern_vec_bad, kern_fp_bad;
  logic     hyp_vec_bad, hyp_fp_bad;
  logic     mon_vec_bad, mon_fp_bad;
  logic     redirect_hit;

  vtc_kern_gate u_kern (
    .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl),
    .vec_en(low_vec_en), .fp_en(low_fp_en),
    .vec_refuse(kern_vec_bad), .fp_refuse(kern_fp_bad), .verdict(kern_v)
  );

  vtc_hyp_gate u_hyp (
    .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl),
    .hyp_present(hyp_present), .host_mode(host_mode),
    .vec_en(hyp_vec_en), .fp_en(hyp_fp_en),
    .vec_trap(hyp_vec_trap), .fp_trap(hyp_fp_trap),
    .vec_refuse(hyp_vec_bad), .fp_refuse(hyp_fp_bad), .verdict(hyp_v)
  );

  vtc_mon_gate u_mon (
    .clk(clk), .rst_n(rst_n), .mon_present(mon_present),
    .vec_on(mon_vec_on), .fp_trap(mon_fp_trap),
    .vec_refuse(mon_vec_bad), .fp_refuse(mon_fp_bad), .verdict(mon_v)
  );

  assign chosen_v = first_fail(kern_v, first_fail(hyp_v, mon_v));

  // Only vector traps aimed at level 1 are redirected
  assign redirect_hit = chosen_v.fail && !chosen_v.is_fp &&
                        (chosen_v.target == LVL_KERN) && hyp_present && trap_gen;

  always_comb begin
    routed_v = chosen_v;
    if (redirect_hit) routed_v.target = LVL_HYP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      allowed    <= 1'b0;
      trap_fp    <= 1'b0;
      target_lvl <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        allowed    <= !routed_v.fail;
        trap_fp    <= routed_v.fail && routed_v.is_fp;
        target_lvl <= routed_v.fail ? routed_v.target : LVL_USER;
      end
    end
  end

  // R2: response follows request by one clock
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R10: a pass carries no trap information
  a_r10_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && allowed) |-> (!trap_fp && target_lvl == LVL_USER));
  // R10: a refusal always names a non-zero target
  a_r10_refusal_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !allowed) |-> (target_lvl != LVL_USER));
  // R8: a kernel-tier refusal decides the verdict
  a_r8_kern_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (kern_vec_bad || kern_fp_bad)) |=>
      (!allowed && (trap_fp == !$past(kern_vec_bad))));
  // R8: hypervisor tier beats monitor tier
  a_r8_hyp_over_mon: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !kern_vec_bad && !kern_fp_bad && (hyp_vec_bad || hyp_fp_bad)) |=>
      (!allowed && target_lvl == LVL_HYP));
  // R7: monitor-only refusal reaches level 3
  a_r7_mon_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !kern_vec_bad && !kern_fp_bad && !hyp_vec_bad && !hyp_fp_bad &&
     (mon_vec_bad || mon_fp_bad)) |=> (!allowed && target_lvl == LVL_MON));
  // R9: with redirection enabled, no vector trap lands on level 1
  a_r9_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hyp_present && trap_gen) |=>
      !(!allowed && !trap_fp && target_lvl == LVL_KERN));
endmodule

// File: tb/vec_trap_chk_tb_top.sv
module vec_trap_chk_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [1:0] cur_lvl, low_vec_en, low_fp_en, hyp_vec_en, hyp_fp_en;
  logic hyp_present, mon_present, host_mode, trap_gen;
  logic hyp_vec_trap, hyp_fp_trap, mon_vec_on, mon_fp_trap;
  logic rsp_valid, allowed, trap_fp;
  logic [1:0] target_lvl;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vec_trap_chk dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_lvl(cur_lvl),
    .hyp_present(hyp_present), .mon_present(mon_present), .host_mode(host_mode),
    .trap_gen(trap_gen), .low_vec_en(low_vec_en), .low_fp_en(low_fp_en),
    .hyp_vec_en(hyp_vec_en), .hyp_fp_en(hyp_fp_en), .hyp_vec_trap(hyp_vec_trap),
    .hyp_fp_trap(hyp_fp_trap), .mon_vec_on(mon_vec_on), .mon_fp_trap(mon_fp_trap),
    .rsp_valid(rsp_valid), .allowed(allowed), .trap_fp(trap_fp), .target_lvl(target_lvl)
  );

  task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic bit refuses2(input logic [1:0] f, input bit at0);
    case (f)
      2'b00, 2'b10: return 1'b1;
      2'b01:        return at0;
      default:      return 1'b0;
    endcase
  endfunction

  // Returns {allowed, trap_fp, target}
  function automatic logic [3:0] model(
      input logic [1:0] lv, input bit hp, input bit mp, input bit hm, input bit tg,
      input logic [1:0] lve, input logic [1:0] lfe, input logic [1:0] hve, input logic [1:0] hfe,
      input bit hvt, input bit hft, input bit mve, input bit mft);
    if (lv <= 2'd1) begin
      if (refuses2(lve, lv == 2'd0)) return (hp && tg) ? 4'b0010 : 4'b0001;
      if (refuses2(lfe, lv == 2'd0)) return 4'b0101;
    end
    if (hp && lv != 2'd3) begin
      if (hm ? (hve[0] == 1'b0) : hvt) return 4'b0010;
      if (hm ? (hfe[0] == 1'b0) : hft) return 4'b0110;
    end
    if (mp) begin
      if (!mve) return 4'b0011;
      if (mft)  return 4'b0111;
    end
    return 4'b1000;
  endfunction

  task automatic run_case(
      input logic [1:0] lv, input bit hp, input bit mp, input bit hm, input bit tg,
      input logic [1:0] lve, input logic [1:0] lfe, input logic [1:0] hve, input logic [1:0] hfe,
      input bit hvt, input bit hft, input bit mve, input bit mft,
      input logic [3:0] exp, input string req);
    logic [3:0] act;
    @(negedge clk);
    cur_lvl = lv; hyp_present = hp; mon_present = mp; host_mode = hm; trap_gen = tg;
    low_vec_en = lve; low_fp_en = lfe; hyp_vec_en = hve; hyp_fp_en = hfe;
    hyp_vec_trap = hvt; hyp_fp_trap = hft; mon_vec_on = mve; mon_fp_trap = mft;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    act = {allowed, trap_fp, target_lvl};
    check(rsp_valid === 1'b1, {req, " R2 rsp_valid"}, {3'b0, rsp_valid}, 4'b0001);
    check(act === exp, req, act, exp);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0;
    cur_lvl = '0; hyp_present = 0; mon_present = 0; host_mode = 0; trap_gen = 0;
    low_vec_en = '0; low_fp_en = '0; hyp_vec_en = '0; hyp_fp_en = '0;
    hyp_vec_trap = 0; hyp_fp_trap = 0; mon_vec_on = 0; mon_fp_trap = 0;
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R1 reset", {3'b0, rsp_valid}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R1 after reset", {3'b0, rsp_valid}, 4'b0000);

    // R3 decode
    run_case(0, 0,0,0,0, 2'b01, 2'b11, 2'b11, 2'b11, 0,0,1,0, 4'b0001, "R3 user-only at L0");
    run_case(1, 0,0,0,0, 2'b01, 2'b01, 2'b11, 2'b11, 0,0,1,0, 4'b1000, "R3 user-only at L1");
    run_case(1, 0,0,0,0, 2'b11, 2'b10, 2'b11, 2'b11, 0,0,1,0, 4'b0101, "R3 fp x0 at L1");
    // R4 vector first
    run_case(0, 0,0,0,0, 2'b00, 2'b00, 2'b11, 2'b11, 0,0,1,0, 4'b0001, "R4 both refuse");
    // R9 redirect
    run_case(0, 1,0,0,1, 2'b01, 2'b11, 2'b11, 2'b11, 0,0,1,0, 4'b0010, "R9 vec redirect");
    run_case(1, 1,0,0,1, 2'b11, 2'b00, 2'b11, 2'b11, 0,0,1,0, 4'b0101, "R9 fp not redirected");
    run_case(1, 0,0,0,1, 2'b00, 2'b11, 2'b11, 2'b11, 0,0,1,0, 4'b0001, "R9 no hyp no redirect");
    // R5 host mode
    run_case(2, 1,0,1,0, 2'b00, 2'b00, 2'b10, 2'b11, 0,0,1,0, 4'b0010, "R5 host vec x0");
    run_case(2, 1,0,1,0, 2'b11, 2'b11, 2'b11, 2'b01, 1,1,1,0, 4'b1000, "R5 host ignores bits");
    run_case(1, 1,0,1,0, 2'b11, 2'b11, 2'b01, 2'b00, 0,0,1,0, 4'b0110, "R5 host fp x0");
    // R6 plain mode
    run_case(2, 1,0,0,0, 2'b11, 2'b11, 2'b00, 2'b00, 0,1,1,0, 4'b0110, "R6 fp trap bit");
    run_case(0, 1,0,0,0, 2'b11, 2'b11, 2'b00, 2'b00, 0,0,1,0, 4'b1000, "R6 fields ignored");
    // R7 monitor
    run_case(3, 0,1,0,0, 2'b00, 2'b00, 2'b00, 2'b00, 1,1,0,1, 4'b0011, "R7 mon vec off");
    run_case(3, 0,1,0,0, 2'b00, 2'b00, 2'b00, 2'b00, 1,1,1,1, 4'b0111, "R7 mon fp trap");
    run_case(3, 0,0,0,0, 2'b00, 2'b00, 2'b00, 2'b00, 1,1,0,1, 4'b1000, "R7 mon absent");
    // R8 priority
    run_case(1, 1,1,0,0, 2'b11, 2'b00, 2'b11, 2'b11, 1,0,0,0, 4'b0101, "R8 kern over hyp/mon");
    run_case(2, 1,1,0,0, 2'b11, 2'b11, 2'b11, 2'b11, 0,1,0,0, 4'b0110, "R8 hyp over mon");
    // R11 scope
    run_case(2, 0,0,0,0, 2'b00, 2'b00, 2'b00, 2'b00, 1,1,1,0, 4'b1000, "R11 kern+hyp inert");
    run_case(3, 1,0,0,1, 2'b00, 2'b00, 2'b00, 2'b00, 1,1,1,0, 4'b1000, "R11 level 3");
    // R10 allowed everywhere
    run_case(0, 1,1,1,1, 2'b11, 2'b11, 2'b11, 2'b11, 0,0,1,0, 4'b1000, "R10 all enabled");

    // R2 no spurious response
    @(negedge clk);
    check(rsp_valid === 1'b0, "R2 idle cycle", {3'b0, rsp_valid}, 4'b0000);

    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 400; i++) begin
      logic [1:0] lv, lve, lfe, hve, hfe;
      bit hp, mp, hm, tg, hvt, hft, mve, mft;
      lv = 2'($urandom); lve = 2'($urandom); lfe = 2'($urandom);
      hve = 2'($urandom); hfe = 2'($urandom);
      hp = 1'($urandom); mp = 1'($urandom); hm = 1'($urandom); tg = 1'($urandom);
      hvt = ($urandom % 4) == 0; hft = ($urandom % 4) == 0;
      mve = ($urandom % 4) != 0; mft = ($urandom % 4) == 0;
      run_case(lv, hp, mp, hm, tg, lve, lfe, hve, hfe, hvt, hft, mve, mft,
               model(lv, hp, mp, hm, tg, lve, lfe, hve, hfe, hvt, hft, mve, mft),
               "R8 random model");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule